// File: doc/BRIEF.md
# Transmit FIFO Space Interrupt Controller

This block is the transmit half of a serial port channel. The host writes bytes into a 64-entry queue, and a downstream serializer takes them out through a pop port. The queue's free space is compared against a programmed threshold. That threshold counts empty slots, not queued bytes. The comparison drives a ready flag, a status bit that software can poll at any time, and a transmit interrupt request.

The transmit request and a receive-data request both feed a small identification register. The host reads that register to learn which source is pending. A read that reports the transmit source acknowledges it. A transmit event that arrives in the same cycle as a read that reports a different source stays latched.

An RS-485 automatic-direction mode, when its logic-control bit is clear, suppresses the threshold interrupt. The ready flag and the status bit are not affected by that mode.

Top module: `uart_txirq_ctrl`

## Requirements
- R1: The queue stores up to 64 bytes and releases them in write order. `level_o` gives the stored count, and `pop_data_o` shows the oldest byte while `pop_valid_o` is 1.
- R2: A write while 64 bytes are stored is dropped: the level stays at 64. The same write sets `ovf_o`, which stays at 1 until reset.
- R3: A pop while the queue is empty changes nothing: the level stays at 0 and `pop_valid_o` stays at 0.
- R4: `txrdy_o` is 1 exactly when (64 − level) ≥ `trig_free_i`. With a threshold of 8 it is 1 at 56 stored bytes and 0 at 57. With a threshold of 64 it is 1 only when the queue is empty. It follows the level in the same cycle.
- R5: `lsr_tx_o` always equals the current space condition of R4. It does not depend on the interrupt enable, the RS-485 gate or any acknowledge.
- R6: Define the transmit condition as `txrdy_o` AND `tx_ie_i` AND the RS-485 gate. When this condition rises, the transmit source becomes pending one cycle later. `irq_o` is then 1 and `iir_o` reads 0x2 if no receive request is present.
- R7: A cycle with `iir_rd_i`=1 while `iir_o` reads 0x2 clears the transmit source. From the next cycle `iir_o` reads 0x1 and `irq_o` is 0, unless another source is present.
- R8: If the transmit condition goes false, the pending transmit source clears on the next cycle, and `iir_o` reads 0x1 when no receive request is present.
- R9: Identification codes are 0x4 for receive, 0x2 for transmit and 0x1 for none. Receive has priority. `irq_o` is 1 while either source is present, and a read that reports 0x4 leaves a pending transmit source in place.
- R10: A transmit condition that rises in the same cycle as a read reporting 0x4 is still latched as pending.
- R11: With `rs485_auto_i`=1 and `rs485_logic_i`=0 the transmit interrupt never becomes pending. Setting `rs485_logic_i`=1 restores normal behaviour, and a transmit condition that is then true raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_data_i | input | 8 | Host write byte |
| pop_i | input | 1 | Serializer pop strobe |
| pop_data_o | output | 8 | Oldest stored byte |
| pop_valid_o | output | 1 | Queue not empty |
| level_o | output | 7 | Stored byte count |
| ovf_o | output | 1 | Sticky write-overflow flag |
| trig_free_i | input | 7 | Free-slot threshold (0..64) |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| rs485_auto_i | input | 1 | RS-485 automatic mode |
| rs485_logic_i | input | 1 | RS-485 logic-control bit, enables threshold interrupt in auto mode |
| rx_req_i | input | 1 | Receive-data interrupt request (level) |
| iir_rd_i | input | 1 | Identification register read strobe |
| iir_o | output | 4 | Identification code |
| irq_o | output | 1 | Interrupt request |
| txrdy_o | output | 1 | Free space at or above threshold |
| lsr_tx_o | output | 1 | Polled transmit space status |

## Verification
The bench checks the threshold at 56 and 57 stored bytes, and at a threshold of 64. A design that counted stored bytes instead of free slots would flip the ready flag at the wrong level. It drives a read that reports the receive code in the same cycle as a rising transmit condition. A design that cleared every source on any read would lose that transmit event. It checks that a pending transmit source vanishes when the queue refills past the threshold, and that the receive-priority read leaves it in place. It also checks that RS-485 auto mode with the logic-control bit clear keeps `irq_o` low while `lsr_tx_o` still reports space. Overflow and underflow strobes are checked for dropping the byte, setting the sticky flag and leaving the level untouched.

// File: rtl/uart_txirq_pkg.sv
package uart_txirq_pkg;
  typedef enum logic [3:0] {
    IIR_NONE = 4'h1,
    IIR_TX   = 4'h2,
    IIR_RX   = 4'h4
  } iir_code_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          wr_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign wr_ok   = wr_en_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_ok)  wp_q <= nxt(wp_q);
      if (pop_ok) rp_q <= nxt(rp_q);
      if (wr_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !wr_ok) cnt_q <= cnt_q - 1'b1;
      if (wr_en_i && full_o) ovf_q <= 1'b1;
    end
  end

  assign rd_data_o = mem_q[rp_q];
  assign count_o   = cnt_q;
  assign ovf_o     = ovf_q;

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_full_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && !pop_i) |=> (cnt_q == CW'(DEPTH)) && ovf_q);
  p_empty_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !wr_en_i) |=> (cnt_q == '0) && $stable(rp_q));
endmodule

// File: rtl/txq_irq.sv
module txq_irq
  import uart_txirq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cond_i,
  input  logic      gate_off_i,
  input  logic      rx_req_i,
  input  logic      rd_i,
  output iir_code_e code_o,
  output logic      irq_o
);
  logic cond_q, pend_q, evt, ack;

  assign code_o = rx_req_i ? IIR_RX : (pend_q ? IIR_TX : IIR_NONE);
  assign irq_o  = rx_req_i | pend_q;
  assign evt    = cond_i & ~cond_q;
  assign ack    = rd_i & (code_o == IIR_TX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cond_q <= cond_i;
      if (!cond_i)  pend_q <= 1'b0;
      else if (evt) pend_q <= 1'b1;   // new event wins over a same-cycle read
      else if (ack) pend_q <= 1'b0;
    end
  end

  p_rise_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cond_i) |=> pend_q);
  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rx_req_i && pend_q && $past(cond_i)) |=> !pend_q);
  p_gone_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_i |=> !pend_q);
  p_rx_read_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rx_req_i && pend_q && cond_i) |=> pend_q);
  p_race_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rx_req_i && cond_i && !cond_q) |=> pend_q);
  p_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_off_i |=> !pend_q);
endmodule

// File: rtl/uart_txirq_ctrl.sv
module uart_txirq_ctrl
  import uart_txirq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o,
  output logic [CW-1:0] level_o,
  output logic          ovf_o,
  input  logic [CW-1:0] trig_free_i,
  input  logic          tx_ie_i,
  input  logic          rs485_auto_i,
  input  logic          rs485_logic_i,
  input  logic          rx_req_i,
  input  logic          iir_rd_i,
  output logic [3:0]    iir_o,
  output logic          irq_o,
  output logic          txrdy_o,
  output logic          lsr_tx_o
);
  logic [CW-1:0] cnt, free_slots;
  logic          empty, full, gate_off, tx_cond;
  iir_code_e     code;

  txq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .pop_i,
    .rd_data_o(pop_data_o), .count_o(cnt), .empty_o(empty),
    .full_o(full), .ovf_o
  );

  assign free_slots = CW'(DEPTH) - cnt;
  assign txrdy_o    = (free_slots >= trig_free_i);
  assign lsr_tx_o   = txrdy_o;
  assign gate_off   = rs485_auto_i & ~rs485_logic_i;
  assign tx_cond    = txrdy_o & tx_ie_i & ~gate_off;

  txq_irq u_irq (
    .clk_i, .rst_ni, .cond_i(tx_cond), .gate_off_i(gate_off),
    .rx_req_i, .rd_i(iir_rd_i), .code_o(code), .irq_o
  );

  assign iir_o       = code;
  assign pop_valid_o = ~empty;
  assign level_o     = cnt;

  p_full_blocks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !txrdy_o || trig_free_i == '0);
endmodule

// File: tb/uart_txirq_ctrl_tb_top.sv
module uart_txirq_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, pop = 0, tx_ie = 0, auto485 = 0, logic485 = 0, rx_req = 0, rd = 0;
  logic [7:0] wr_data = 0, pop_data;
  logic [6:0] trig = 7'd8, level;
  logic pop_valid, ovf, irq, txrdy, lsr_tx;
  logic [3:0] iir;
  int checks = 0, failures = 0, lvl = 0;

  always #4 clk = ~clk;

  uart_txirq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .pop_i(pop),
    .pop_data_o(pop_data), .pop_valid_o(pop_valid), .level_o(level), .ovf_o(ovf),
    .trig_free_i(trig), .tx_ie_i(tx_ie), .rs485_auto_i(auto485), .rs485_logic_i(logic485),
    .rx_req_i(rx_req), .iir_rd_i(rd), .iir_o(iir), .irq_o(irq), .txrdy_o(txrdy),
    .lsr_tx_o(lsr_tx)
  );

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1; wr_data = b; tick; wr_en = 0;
    if (lvl < 64) lvl++;
  endtask

  task automatic pop1;
    pop = 1; tick; pop = 0;
    if (lvl > 0) lvl--;
  endtask

  task automatic read_iir; rd = 1; tick; rd = 0; endtask

  task automatic fill_to(int n); while (lvl < n) wr(8'(lvl)); endtask
  task automatic drain_to(int n); while (lvl > n) pop1; endtask

  task automatic t_reset;
    chk("R1 reset level", level, 0);
    chk("R4 reset txrdy", txrdy, 1);
    chk("R9 reset iir", iir, 1);
    chk("R6 reset irq", irq, 0);
    chk("R2 reset ovf", ovf, 0);
  endtask

  task automatic t_order;
    for (int i = 0; i < 5; i++) wr(8'h30 + 8'(i));
    chk("R1 level after 5", level, 5);
    for (int i = 0; i < 5; i++) begin
      chk("R1 pop order", pop_data, 8'h30 + i);
      pop1;
    end
    chk("R1 level drained", level, 0);
  endtask

  task automatic t_underflow;
    pop1;
    chk("R3 empty pop level", level, 0);
    chk("R3 empty pop valid", pop_valid, 0);
  endtask

  task automatic t_threshold;
    trig = 7'd64; #1;
    chk("R4 trig64 empty", txrdy, 1);
    wr(8'h55);
    chk("R4 trig64 one stored", txrdy, 0);
    pop1; trig = 7'd8; #1;
    fill_to(56);
    chk("R4 56 stored", txrdy, 1);
    chk("R5 56 status", lsr_tx, 1);
    wr(8'h77);
    chk("R4 57 stored", txrdy, 0);
    chk("R5 57 status", lsr_tx, 0);
  endtask

  task automatic t_overflow;
    fill_to(64);
    chk("R2 no ovf yet", ovf, 0);
    wr(8'hEE);
    chk("R2 full level", level, 64);
    chk("R2 ovf set", ovf, 1);
    chk("R1 head kept", pop_data, 0);
    drain_to(57);
    chk("R2 ovf sticky", ovf, 1);
  endtask

  task automatic t_irq_ack;
    tx_ie = 1; tick;
    chk("R6 no irq above level", irq, 0);
    pop1;
    chk("R4 txrdy same cycle", txrdy, 1);
    chk("R6 irq one cycle later", irq, 0);
    tick;
    chk("R6 irq raised", irq, 1);
    chk("R6 iir tx", iir, 2);
    read_iir;
    chk("R7 irq after ack", irq, 0);
    chk("R7 iir after ack", iir, 1);
    chk("R5 status after ack", lsr_tx, 1);
  endtask

  task automatic t_gone;
    wr(8'h01); pop1; tick;
    chk("R6 re-raised", iir, 2);
    wr(8'h02); tick;
    chk("R8 iir cleared", iir, 1);
    chk("R8 irq dropped", irq, 0);
  endtask

  task automatic t_prio;
    pop1; tick;
    rx_req = 1; #1;
    chk("R9 rx priority code", iir, 4);
    read_iir;
    chk("R9 code after rx read", iir, 4);
    chk("R9 irq held", irq, 1);
    rx_req = 0; #1;
    chk("R9 tx kept", iir, 2);
    read_iir;
    chk("R7 ack after rx gone", iir, 1);
  endtask

  task automatic t_race;
    wr(8'h03); tick;
    chk("R10 setup none", iir, 1);
    rx_req = 1;
    pop1;
    read_iir;
    chk("R10 code during rx", iir, 4);
    rx_req = 0; #1;
    chk("R10 tx latched", iir, 2);
    chk("R10 irq latched", irq, 1);
    read_iir;
    chk("R7 ack race", iir, 1);
  endtask

  task automatic t_rs485;
    wr(8'h04); tick;
    auto485 = 1; logic485 = 0;
    pop1; tick; tick;
    chk("R11 gated irq", irq, 0);
    chk("R11 gated iir", iir, 1);
    chk("R5 status in gated mode", lsr_tx, 1);
    logic485 = 1; tick;
    chk("R11 logic bit irq", irq, 1);
    chk("R11 logic bit iir", iir, 2);
    read_iir;
    chk("R7 ack rs485", irq, 0);
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1; tick;
    t_reset;
    t_order;
    t_underflow;
    t_threshold;
    t_overflow;
    t_irq_ack;
    t_gone;
    t_prio;
    t_race;
    t_rs485;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule